// File: doc/BRIEF.md
# Vector Pack/Unpack Element Index Sequencer

This block drives the element loop of a vector move that interleaves or de-interleaves data. After a start strobe it walks a two-dimensional matrix of `ydim` rows by `xdim` columns and, once per clock, presents a source and a destination register element position. The source offset simply counts up. The destination offset is the transposed position in the matrix, so the data is reordered as it moves.

A mode input chooses between pack and unpack. The span on one side of the move may be twice the vector length, and in that case a second register group is implied. In pack mode the second group is on the source side, and in unpack mode it is on the destination side. Any offset on that side that reaches the vector length is reported as the base register plus the vector length, with the element number reduced by the vector length. Two predicate masks, one per side, can suppress individual steps. The register file and the data path take the index stream and do the actual moves.

Top module: `elem_seq_top`

## Requirements
- R1: After reset `out_valid` and `done` are low, and they stay low until a start is accepted.
- R2: A start accepted while idle, with `ydim`*`xdim` = N > 0, runs N steps on consecutive cycles. Step i (0 to N-1) is visible in the (i+1)-th cycle after the start edge. Its source offset is i and its destination offset is (i mod `xdim`)*`ydim` + (i div `xdim`). For example, 2x4 gives destination offsets 0,2,4,6,1,3,5,7 and 3x3 gives 0,3,6,1,4,7,2,5,8.
- R3: With `mode_pack`=1, a source offset s >= `maxvl` is output as register `src_base`+`maxvl` and element s-`maxvl`. Otherwise the source is `src_base` with element s. The destination is always `dst_base` with its raw offset.
- R4: With `mode_pack`=0, a destination offset d >= `maxvl` is output as register `dst_base`+`maxvl` and element d-`maxvl`. Otherwise the destination is `dst_base` with element d. The source is always `src_base` with its raw offset.
- R5: If bit s of `src_mask` is 0, the step with source offset s still takes its cycle, but `out_valid` is low in that cycle.
- R6: If bit d of `dst_mask` is 0, the step with destination offset d still takes its cycle, but `out_valid` is low in that cycle.
- R7: `done` is high for exactly one cycle, the cycle after the last step is visible. It is never high together with `out_valid`.
- R8: If `ydim` or `xdim` is 0, `done` is high in the first cycle after the start edge and no step is output.
- R9: While a sequence is running, `start` and every configuration input are ignored. The stream continues unchanged.
- R10: All configuration inputs and both masks are captured at the accepted start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| mode_pack | input | 1 | 1 = pack (source span doubled), 0 = unpack (destination span doubled) |
| src_base | input | REG_W | Base source register number |
| dst_base | input | REG_W | Base destination register number |
| maxvl | input | IDX_W | Vector length of one register group |
| ydim | input | DIM_W | Matrix Y dimension |
| xdim | input | DIM_W | Matrix X dimension |
| src_mask | input | 2**IDX_W | Source predicate, indexed by source offset |
| dst_mask | input | 2**IDX_W | Destination predicate, indexed by destination offset |
| out_valid | output | 1 | Current step is a live move |
| out_src_reg | output | REG_W | Source register number |
| out_src_elem | output | IDX_W | Source element within that register group |
| out_dst_reg | output | REG_W | Destination register number |
| out_dst_elem | output | IDX_W | Destination element within that register group |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Every output is registered once after the counters, so step i of a sequence shows up i+1 cycles after the start edge. `done` follows N+1 cycles after that edge, or one cycle after it for an empty matrix. The bench drives inputs on falling edges and counts falling edges from the start edge. It compares each step against the transposed offsets and the split rule it computes itself, in exactly the cycle where that step is due. It also samples `done` in its due cycle and in the cycle after, and checks that a masked step leaves `out_valid` low in its own slot without moving later steps.

// File: rtl/elem_seq_pkg.sv
package elem_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;
endpackage

// File: rtl/elem_walker.sv
module elem_walker #(
  parameter int IDX_W = 6,
  parameter int DIM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [DIM_W-1:0] ydim,
  input  logic [DIM_W-1:0] xdim,
  output logic [IDX_W-1:0] lin_off,
  output logic [IDX_W-1:0] tr_off,
  output logic             last
);
  logic [DIM_W-1:0] col_q, row_q;
  logic [IDX_W-1:0] lin_q, tr_q;
  logic             col_end;

  assign col_end = (col_q == xdim - DIM_W'(1));
  assign last    = col_end && (row_q == ydim - DIM_W'(1));
  assign lin_off = lin_q;
  assign tr_off  = tr_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      col_q <= '0;
      row_q <= '0;
      lin_q <= '0;
      tr_q  <= '0;
    end else if (adv) begin
      lin_q <= lin_q + IDX_W'(1);
      if (col_end) begin
        col_q <= '0;
        row_q <= row_q + DIM_W'(1);
        tr_q  <= IDX_W'(row_q) + IDX_W'(1);
      end else begin
        col_q <= col_q + DIM_W'(1);
        tr_q  <= tr_q + IDX_W'(ydim);
      end
    end
  end

  p_col_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    adv |-> (col_q < xdim));

  p_tr_in_matrix_r2: assert property (@(posedge clk) disable iff (rst)
    adv |-> (int'(tr_q) < int'(ydim) * int'(xdim)));
endmodule

// File: rtl/span_split.sv
module span_split #(
  parameter int IDX_W = 6,
  parameter int REG_W = 7
) (
  input  logic             wide_en,
  input  logic [IDX_W-1:0] offset,
  input  logic [REG_W-1:0] base,
  input  logic [IDX_W-1:0] maxvl,
  output logic [REG_W-1:0] reg_num,
  output logic [IDX_W-1:0] elem
);
  logic upper;

  always_comb begin
    upper   = wide_en && (offset >= maxvl);
    reg_num = upper ? base + REG_W'(maxvl) : base;
    elem    = upper ? offset - maxvl : offset;
  end
endmodule

// File: rtl/elem_seq_top.sv
module elem_seq_top
  import elem_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DIM_W = 4,
  parameter int REG_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  mode_pack,
  input  logic [REG_W-1:0]      src_base,
  input  logic [REG_W-1:0]      dst_base,
  input  logic [IDX_W-1:0]      maxvl,
  input  logic [DIM_W-1:0]      ydim,
  input  logic [DIM_W-1:0]      xdim,
  input  logic [(1<<IDX_W)-1:0] src_mask,
  input  logic [(1<<IDX_W)-1:0] dst_mask,
  output logic                  out_valid,
  output logic [REG_W-1:0]      out_src_reg,
  output logic [IDX_W-1:0]      out_src_elem,
  output logic [REG_W-1:0]      out_dst_reg,
  output logic [IDX_W-1:0]      out_dst_elem,
  output logic                  done
);
  localparam int NEL = 1 << IDX_W;

  seq_state_t       st_q;
  logic             pack_q;
  logic [REG_W-1:0] sbase_q, dbase_q;
  logic [IDX_W-1:0] mvl_q;
  logic [DIM_W-1:0] ydim_q, xdim_q;
  logic [NEL-1:0]   smask_q, dmask_q;

  logic             accept, empty, running, last;
  logic [IDX_W-1:0] lin_off, tr_off;
  logic             live;

  logic [IDX_W-1:0] side_off  [2];
  logic [REG_W-1:0] side_base [2];
  logic             side_wide [2];
  logic [REG_W-1:0] side_reg  [2];
  logic [IDX_W-1:0] side_elem [2];

  assign accept  = (st_q == ST_IDLE) && start;
  assign empty   = (ydim == '0) || (xdim == '0);
  assign running = (st_q == ST_RUN);

  elem_walker #(.IDX_W(IDX_W), .DIM_W(DIM_W)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .adv    (running),
    .ydim   (ydim_q),
    .xdim   (xdim_q),
    .lin_off(lin_off),
    .tr_off (tr_off),
    .last   (last)
  );

  assign side_off[SIDE_SRC]  = lin_off;
  assign side_off[SIDE_DST]  = tr_off;
  assign side_base[SIDE_SRC] = sbase_q;
  assign side_base[SIDE_DST] = dbase_q;
  assign side_wide[SIDE_SRC] = pack_q;
  assign side_wide[SIDE_DST] = !pack_q;

  for (genvar g = 0; g < 2; g++) begin : g_side
    span_split #(.IDX_W(IDX_W), .REG_W(REG_W)) u_split (
      .wide_en(side_wide[g]),
      .offset (side_off[g]),
      .base   (side_base[g]),
      .maxvl  (mvl_q),
      .reg_num(side_reg[g]),
      .elem   (side_elem[g])
    );
  end

  assign live = smask_q[lin_off] && dmask_q[tr_off];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pack_q  <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
      mvl_q   <= '0;
      ydim_q  <= '0;
      xdim_q  <= '0;
      smask_q <= '0;
      dmask_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          pack_q  <= mode_pack;
          sbase_q <= src_base;
          dbase_q <= dst_base;
          mvl_q   <= maxvl;
          ydim_q  <= ydim;
          xdim_q  <= xdim;
          smask_q <= src_mask;
          dmask_q <= dst_mask;
          st_q    <= empty ? ST_IDLE : ST_RUN;
        end
        ST_RUN:  if (last) st_q <= ST_FIN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      done         <= 1'b0;
      out_src_reg  <= '0;
      out_src_elem <= '0;
      out_dst_reg  <= '0;
      out_dst_elem <= '0;
    end else begin
      out_valid <= running && live;
      done      <= (st_q == ST_FIN) || (accept && empty);
      if (running) begin
        out_src_reg  <= side_reg[SIDE_SRC];
        out_src_elem <= side_elem[SIDE_SRC];
        out_dst_reg  <= side_reg[SIDE_DST];
        out_dst_elem <= side_elem[SIDE_DST];
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_excl_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && out_valid));

  p_cfg_held_r9: assert property (@(posedge clk) disable iff (rst)
    running |=> ($stable(ydim_q) && $stable(xdim_q) && $stable(pack_q) && $stable(mvl_q)));

  p_upper_src_elem_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pack_q && out_src_reg != sbase_q) |-> (out_src_elem < mvl_q));

  p_unpack_src_flat_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pack_q) |-> (out_src_reg == sbase_q));

  p_pack_dst_flat_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pack_q) |-> (out_dst_reg == dbase_q));
endmodule

// File: tb/elem_seq_top_bench.sv
module elem_seq_top_bench;
  localparam int IDX_W = 6;
  localparam int DIM_W = 4;
  localparam int REG_W = 7;
  localparam int NEL   = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             mode_pack = 1'b0;
  logic [REG_W-1:0] src_base = '0, dst_base = '0;
  logic [IDX_W-1:0] maxvl = '0;
  logic [DIM_W-1:0] ydim = '0, xdim = '0;
  logic [NEL-1:0]   src_mask = '1, dst_mask = '1;
  logic             out_valid, done;
  logic [REG_W-1:0] out_src_reg, out_dst_reg;
  logic [IDX_W-1:0] out_src_elem, out_dst_elem;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  elem_seq_top #(.IDX_W(IDX_W), .DIM_W(DIM_W), .REG_W(REG_W)) u_elem_seq_top (
    .clk(clk), .rst(rst), .start(start), .mode_pack(mode_pack),
    .src_base(src_base), .dst_base(dst_base), .maxvl(maxvl),
    .ydim(ydim), .xdim(xdim), .src_mask(src_mask), .dst_mask(dst_mask),
    .out_valid(out_valid), .out_src_reg(out_src_reg), .out_src_elem(out_src_elem),
    .out_dst_reg(out_dst_reg), .out_dst_elem(out_dst_elem), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one sequence and checks every step and done in the cycle they are due.
  // poke_at >= 0: at that step, raise start with scrambled inputs (R9).
  task automatic run_seq(input string req, input bit pk, input int ra, input int rt,
                         input int mv, input int yd, input int xd,
                         input logic [NEL-1:0] sm, input logic [NEL-1:0] dm,
                         input int poke_at);
    int n;
    n = yd * xd;
    @(negedge clk);
    mode_pack = pk; src_base = REG_W'(ra); dst_base = REG_W'(rt);
    maxvl = IDX_W'(mv); ydim = DIM_W'(yd); xdim = DIM_W'(xd);
    src_mask = sm; dst_mask = dm; start = 1'b1;
    @(negedge clk);                       // start edge has passed
    start = 1'b0;
    if (n == 0) begin
      check(done == 1'b1 && out_valid == 1'b0, "R8", "empty done",
            {out_valid, done}, 64'b01);
    end
    for (int i = 0; i < n; i++) begin
      int d, es, ed, rs, rd;
      bit v;
      if (i == poke_at) begin
        start = 1'b1; mode_pack = ~pk; ydim = 4'd1; xdim = 4'd1;
        maxvl = 6'd1; src_mask = '0; src_base = 7'd99;
      end
      d  = (i % xd) * yd + (i / xd);
      v  = sm[i] && dm[d];
      rs = ra; es = i; rd = rt; ed = d;
      if (pk && i >= mv) begin rs = ra + mv; es = i - mv; end
      if (!pk && d >= mv) begin rd = rt + mv; ed = d - mv; end
      @(negedge clk);                     // step i now visible
      start = 1'b0;
      check(out_valid == v && done == 1'b0, req, $sformatf("step %0d valid", i),
            {out_valid, done}, {v, 1'b0});
      if (v)
        check(out_src_reg == REG_W'(rs) && out_src_elem == IDX_W'(es) &&
              out_dst_reg == REG_W'(rd) && out_dst_elem == IDX_W'(ed),
              req, $sformatf("step %0d indices", i),
              {out_src_reg, out_src_elem, out_dst_reg, out_dst_elem},
              {REG_W'(rs), IDX_W'(es), REG_W'(rd), IDX_W'(ed)});
    end
    if (n > 0) begin
      @(negedge clk);
      check(done == 1'b1 && out_valid == 1'b0, "R7", "done due",
            {out_valid, done}, 64'b01);
    end
    @(negedge clk);
    check(done == 1'b0 && out_valid == 1'b0, "R7", "done one cycle",
          {out_valid, done}, 64'b00);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && done == 1'b0, "R1", "in reset", {out_valid, done}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && done == 1'b0, "R1", "idle after reset", {out_valid, done}, 0);
  endtask

  task automatic t_unpack_2x4;   // R2 R4 R10: de-interleave into two groups
    run_seq("R4", 1'b0, 8, 40, 4, 2, 4, '1, '1, -1);
  endtask

  task automatic t_pack_3x3;     // R2 R3: source spans two groups
    run_seq("R3", 1'b1, 20, 50, 5, 3, 3, '1, '1, -1);
  endtask

  task automatic t_flat_3x2;     // R2: span below maxvl, no split
    run_seq("R2", 1'b0, 1, 2, 32, 3, 2, '1, '1, -1);
  endtask

  task automatic t_src_mask;     // R5: clear source bits 1 and 5
    logic [NEL-1:0] m;
    m = '1; m[1] = 1'b0; m[5] = 1'b0;
    run_seq("R5", 1'b0, 8, 40, 4, 2, 4, m, '1, -1);
  endtask

  task automatic t_dst_mask;     // R6: clear destination bits 3 and 6
    logic [NEL-1:0] m;
    m = '1; m[3] = 1'b0; m[6] = 1'b0;
    run_seq("R6", 1'b1, 20, 50, 5, 3, 3, '1, m, -1);
  endtask

  task automatic t_empty;        // R8
    run_seq("R8", 1'b0, 3, 4, 4, 0, 5, '1, '1, -1);
    run_seq("R8", 1'b1, 3, 4, 4, 4, 0, '1, '1, -1);
  endtask

  task automatic t_busy_start;   // R9 R10: start and new inputs mid-run ignored
    run_seq("R9", 1'b0, 10, 30, 6, 3, 4, '1, '1, 2);
  endtask

  task automatic t_single;       // R2 R7: 1x1 step then done
    run_seq("R2", 1'b1, 5, 6, 1, 1, 1, '1, '1, -1);
  endtask

  initial begin
    t_reset();
    t_unpack_2x4();
    t_pack_3x3();
    t_flat_3x2();
    t_src_mask();
    t_dst_mask();
    t_empty();
    t_busy_start();
    t_single();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule